// File: doc/BRIEF.md
# Branch, Call and Return Sequencer

This block produces the next program counter for a small nibble-oriented processor with a 16-bit PC. It handles all program flow instructions on a 13-bit opcode:

- plain and flag-conditional relative jumps;
- jumps through the A, B:A and Y registers;
- jumps and calls whose offset is read from a page-zero byte;
- absolute and relative calls;
- a software interrupt;
- four flavours of return.

Any other opcode simply advances the PC by one.

Return addresses live on an address stack of 16-bit words. The block keeps the pointer for that stack, and each entry covers four nibbles of data space. Flags are saved on a separate nibble stack with its own pointer. A single nibble memory port is shared between three kinds of access:

- flag saves and restores;
- page-zero operand reads;
- the two nibble writes of the data-storing return.

The core presents an opcode with `opValid`. Instructions of two or three cycles latch the opcode, and hold `busy` high in every cycle except their last. The PC register is loaded once, at the edge that ends the instruction. The block drives the flag and X register updates of the core through write strobes.

Top module: `branch_sequencer`

## Requirements
- R1: After reset `pc` equals RESET_PC, `sp1` equals SP1_INIT, `sp2` equals SP2_INIT, and `busy` is low.
- R2: An opcode outside the branch group (for example 0x0800) takes one cycle and sets PC to PC+1.
- R3: Opcode bits [12:8]=00000 jump relative: PC becomes PC+s+1, where s is bits [7:0] read as signed.
- R4: Prefixes 00100, 00101, 00110 and 00111 jump relative when C=1, C=0, Z=1 and Z=0 respectively, and otherwise go to PC+1. The flags nibble is {E,I,C,Z} from bit 3 down to bit 0.
- R5: Opcode 0x1FF1 sets PC to PC+A+1, 0x1FF0 to PC+{B,A}+1, and 0x1FF2/0x1FF3 load PC from Y, each in one cycle.
- R6: Opcode 0x1F40|a (a six bits wide) jumps to PC+v+1 in two cycles. Here v is an unsigned byte whose low nibble is at address a and whose high nibble is at a+1.
- R7: A call writes PC+1 to the stack word at nibble address (SP1-1)*4 and decrements SP1. Prefix 00011 loads PC with bits [7:0] and prefix 00010 loads it relative, both in one cycle. 0x1F00|a is the page-zero form of the R6 jump and takes two cycles.
- R8: Opcode 0x1F80|i takes three cycles. It writes F to nibble address SP2-1 and decrements SP2, pushes PC+1 as in R7, and sets PC to 0x0100+i.
- R9: Opcodes 0x1FF8 and 0x1FFA load PC from the stack word at nibble address SP1*4 and increment SP1, in one cycle.
- R10: Opcode 0x1FFB pops as in R9 and sets PC to the popped value plus one, in two cycles.
- R11: Opcode 0x1FF9 pops PC as in R9, then loads F from nibble address SP2 and increments SP2, in two cycles.
- R12: Prefix 10001 pops PC as in R9 and writes bits [3:0] at address X and bits [7:4] at X+1. It then sets X to X+2, and takes three cycles in all.
- R13: `busy` is high in each cycle of an instruction but its last. `pc` does not change while `busy` is high, and `opValid` and `opcode` are ignored until the instruction ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Opcode present this cycle |
| opcode | input | 13 | Instruction word |
| regA | input | 4 | A register |
| regB | input | 4 | B register |
| regX | input | 16 | X register |
| regY | input | 16 | Y register |
| flagsIn | input | 4 | Flags {E,I,C,Z} |
| memRdata | input | 4 | Nibble memory read data |
| stkRdata | input | 16 | Address stack read data |
| pc | output | 16 | Program counter |
| busy | output | 1 | Instruction continues next cycle |
| sp1 | output | 8 | Address stack pointer |
| sp2 | output | 8 | Flag stack pointer |
| memAddr | output | 16 | Nibble memory address |
| memWe | output | 1 | Nibble memory write enable |
| memWdata | output | 4 | Nibble memory write data |
| stkAddr | output | 16 | Address stack nibble address of the entry |
| stkWe | output | 1 | Address stack write enable |
| stkWdata | output | 16 | Address stack write data |
| flagsOut | output | 4 | Restored flags |
| flagsWe | output | 1 | Load flags from flagsOut |
| xOut | output | 16 | New X value |
| xWe | output | 1 | Load X from xOut |

## Verification
- **When results appear.** An instruction's results appear at the clock edge that ends its last cycle. That is one, two or three edges after the edge that accepts the opcode. PC, both pointers, the flags and X are all registered there.
- **How the checks sample.** The monitor samples `busy` a few nanoseconds after each falling edge to count the cycles of the instruction. Once it sees `busy` low, it compares every expected value at the following falling edge, so each value is read half a cycle after the edge that updated it.
- **Cycle counts.** The cycle count itself is compared against the one the requirement states.
- **Stack and memory contents.** These are compared only after the instruction has completed.

// File: rtl/brseq_pkg.sv
package brseq_pkg;
  localparam int OP_W   = 13;
  localparam int STEP_W = 2;

  typedef enum logic [3:0] {
    PC_NEXT, PC_REL, PC_ADDA, PC_ADDBA, PC_REGY, PC_ABS,
    PC_VEC, PC_PAGE, PC_STK, PC_HELD, PC_HELDINC
  } pcSrcE;

  typedef enum logic [3:0] {
    K_SEQ, K_JR, K_JCC, K_JA, K_JBA, K_JY, K_JPZ, K_CPZ,
    K_CALZ, K_CALR, K_INT, K_RET, K_RETS, K_RETD, K_RETI
  } kindE;

  typedef struct packed {
    logic       pcLd;
    pcSrcE      pcSrc;
    logic       stkPush;
    logic       stkPop;
    logic       fPush;
    logic       fPop;
    logic       pzLo;
    logic       pzHi;
    logic       xLo;
    logic       xHi;
    logic       xAdd;
    logic [7:0] arg;
  } strobeT;
endpackage

// File: rtl/brseq_ctrl.sv
module brseq_ctrl
  import brseq_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            opValid,
  input  logic [OP_W-1:0] opcode,
  input  logic            carryF,
  input  logic            zeroF,
  output logic            busy,
  output strobeT          stb
);
  logic [STEP_W-1:0] step, lastStep;
  logic [OP_W-1:0]   heldOp, curOp;
  kindE              kind;
  logic              active, taken;

  assign curOp  = (step == '0) ? opcode : heldOp;
  assign active = opValid || (step != '0);
  assign busy   = active && (step != lastStep);

  always_comb begin
    kind = K_SEQ;
    lastStep = '0;
    case (curOp[12:8])
      5'b00000: kind = K_JR;
      5'b00100, 5'b00101, 5'b00110, 5'b00111: kind = K_JCC;
      5'b00010: kind = K_CALR;
      5'b00011: kind = K_CALZ;
      5'b10001: begin kind = K_RETD; lastStep = 2'd2; end
      5'b11111: begin
        case (curOp[7:6])
          2'b00: begin kind = K_CPZ; lastStep = 2'd1; end
          2'b01: begin kind = K_JPZ; lastStep = 2'd1; end
          2'b10: begin kind = K_INT; lastStep = 2'd2; end
          default: begin
            casez (curOp[5:0])
              6'b110001: kind = K_JA;
              6'b110000: kind = K_JBA;
              6'b11001?: kind = K_JY;
              6'b1110?0: kind = K_RET;
              6'b111011: begin kind = K_RETS; lastStep = 2'd1; end
              6'b111001: begin kind = K_RETI; lastStep = 2'd1; end
              default:   kind = K_SEQ;
            endcase
          end
        endcase
      end
      default: kind = K_SEQ;
    endcase
  end

  always_comb begin
    case (curOp[9:8])
      2'b00:   taken = carryF;
      2'b01:   taken = !carryF;
      2'b10:   taken = zeroF;
      default: taken = !zeroF;
    endcase
  end

  always_comb begin
    stb = '0;
    stb.pcSrc = PC_NEXT;
    stb.arg = curOp[7:0];
    if (active) begin
      case (kind)
        K_JR:   begin stb.pcLd = 1'b1; stb.pcSrc = PC_REL; end
        K_JCC:  begin stb.pcLd = 1'b1; stb.pcSrc = taken ? PC_REL : PC_NEXT; end
        K_JA:   begin stb.pcLd = 1'b1; stb.pcSrc = PC_ADDA; end
        K_JBA:  begin stb.pcLd = 1'b1; stb.pcSrc = PC_ADDBA; end
        K_JY:   begin stb.pcLd = 1'b1; stb.pcSrc = PC_REGY; end
        K_JPZ, K_CPZ: begin
          if (step == 2'd0) stb.pzLo = 1'b1;
          else begin
            stb.pzHi = 1'b1;
            stb.pcLd = 1'b1;
            stb.pcSrc = PC_PAGE;
            stb.stkPush = (kind == K_CPZ);
          end
        end
        K_CALZ: begin stb.pcLd = 1'b1; stb.pcSrc = PC_ABS; stb.stkPush = 1'b1; end
        K_CALR: begin stb.pcLd = 1'b1; stb.pcSrc = PC_REL; stb.stkPush = 1'b1; end
        K_INT: begin
          if (step == 2'd0)      stb.fPush = 1'b1;
          else if (step == 2'd1) stb.stkPush = 1'b1;
          else begin stb.pcLd = 1'b1; stb.pcSrc = PC_VEC; end
        end
        K_RET:  begin stb.stkPop = 1'b1; stb.pcLd = 1'b1; stb.pcSrc = PC_STK; end
        K_RETS: begin
          if (step == 2'd0) stb.stkPop = 1'b1;
          else begin stb.pcLd = 1'b1; stb.pcSrc = PC_HELDINC; end
        end
        K_RETD: begin
          if (step == 2'd0)      begin stb.stkPop = 1'b1; stb.xLo = 1'b1; end
          else if (step == 2'd1) stb.xHi = 1'b1;
          else begin stb.xAdd = 1'b1; stb.pcLd = 1'b1; stb.pcSrc = PC_HELD; end
        end
        K_RETI: begin
          if (step == 2'd0) stb.stkPop = 1'b1;
          else begin stb.fPop = 1'b1; stb.pcLd = 1'b1; stb.pcSrc = PC_HELD; end
        end
        default: stb.pcLd = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      step   <= '0;
      heldOp <= '0;
    end else if (active) begin
      if (step == '0) heldOp <= opcode;
      step <= (step == lastStep) ? '0 : step + 1'b1;
    end
  end
endmodule

// File: rtl/brseq_dpath.sv
module brseq_dpath
  import brseq_pkg::*;
#(
  parameter int PC_W     = 16,
  parameter int SP_W     = 8,
  parameter int RESET_PC = 0,
  parameter int SP1_INIT = 64,
  parameter int SP2_INIT = 200,
  parameter int VEC_BASE = 'h100
) (
  input  logic            clk,
  input  logic            rstN,
  input  strobeT          stb,
  input  logic [3:0]      regA,
  input  logic [3:0]      regB,
  input  logic [PC_W-1:0] regX,
  input  logic [PC_W-1:0] regY,
  input  logic [3:0]      flagsIn,
  input  logic [3:0]      memRdata,
  input  logic [PC_W-1:0] stkRdata,
  output logic [PC_W-1:0] pc,
  output logic [SP_W-1:0] sp1,
  output logic [SP_W-1:0] sp2,
  output logic [PC_W-1:0] memAddr,
  output logic            memWe,
  output logic [3:0]      memWdata,
  output logic [PC_W-1:0] stkAddr,
  output logic            stkWe,
  output logic [PC_W-1:0] stkWdata,
  output logic [3:0]      flagsOut,
  output logic            flagsWe,
  output logic [PC_W-1:0] xOut,
  output logic            xWe
);
  localparam logic [SP_W-1:0] SP_ONE = SP_W'(1);
  localparam logic [PC_W-1:0] VEC    = PC_W'(VEC_BASE);

  logic [PC_W-1:0] pcQ, pcInc, pcNext, relOff, popQ, pzAddr;
  logic [SP_W-1:0] sp1Q, sp2Q, sp1Dn, sp2Dn;
  logic [3:0]      loQ;

  assign pcInc  = pcQ + 1'b1;
  assign relOff = {{(PC_W-8){stb.arg[7]}}, stb.arg};
  assign sp1Dn  = sp1Q - SP_ONE;
  assign sp2Dn  = sp2Q - SP_ONE;
  assign pzAddr = PC_W'(stb.arg[5:0]);

  always_comb begin
    case (stb.pcSrc)
      PC_REL:     pcNext = pcInc + relOff;
      PC_ADDA:    pcNext = pcInc + PC_W'(regA);
      PC_ADDBA:   pcNext = pcInc + PC_W'({regB, regA});
      PC_REGY:    pcNext = regY;
      PC_ABS:     pcNext = PC_W'(stb.arg);
      PC_VEC:     pcNext = VEC + PC_W'(stb.arg[5:0]);
      PC_PAGE:    pcNext = pcInc + PC_W'({memRdata, loQ});
      PC_STK:     pcNext = stkRdata;
      PC_HELD:    pcNext = popQ;
      PC_HELDINC: pcNext = popQ + 1'b1;
      default:    pcNext = pcInc;
    endcase
  end

  always_comb begin
    if (stb.fPush)     memAddr = PC_W'(sp2Dn);
    else if (stb.fPop) memAddr = PC_W'(sp2Q);
    else if (stb.pzLo) memAddr = pzAddr;
    else if (stb.pzHi) memAddr = pzAddr + 1'b1;
    else if (stb.xLo)  memAddr = regX;
    else if (stb.xHi)  memAddr = regX + 1'b1;
    else               memAddr = '0;
  end

  assign memWe    = stb.fPush || stb.xLo || stb.xHi;
  assign memWdata = stb.fPush ? flagsIn : (stb.xLo ? stb.arg[3:0] : stb.arg[7:4]);
  assign stkAddr  = stb.stkPush ? PC_W'({sp1Dn, 2'b00}) : PC_W'({sp1Q, 2'b00});
  assign stkWe    = stb.stkPush;
  assign stkWdata = pcInc;
  assign flagsOut = memRdata;
  assign flagsWe  = stb.fPop;
  assign xOut     = regX + PC_W'(2);
  assign xWe      = stb.xAdd;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcQ  <= PC_W'(RESET_PC);
      sp1Q <= SP_W'(SP1_INIT);
      sp2Q <= SP_W'(SP2_INIT);
      popQ <= '0;
      loQ  <= '0;
    end else begin
      if (stb.pcLd)    pcQ  <= pcNext;
      if (stb.stkPush) sp1Q <= sp1Dn;
      if (stb.stkPop) begin
        sp1Q <= sp1Q + SP_ONE;
        popQ <= stkRdata;
      end
      if (stb.fPush) sp2Q <= sp2Dn;
      if (stb.fPop)  sp2Q <= sp2Q + SP_ONE;
      if (stb.pzLo)  loQ  <= memRdata;
    end
  end

  assign pc  = pcQ;
  assign sp1 = sp1Q;
  assign sp2 = sp2Q;
endmodule

// File: rtl/branch_sequencer.sv
module branch_sequencer
  import brseq_pkg::*;
#(
  parameter int PC_W     = 16,
  parameter int SP_W     = 8,
  parameter int RESET_PC = 0,
  parameter int SP1_INIT = 64,
  parameter int SP2_INIT = 200,
  parameter int VEC_BASE = 'h100
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            opValid,
  input  logic [12:0]     opcode,
  input  logic [3:0]      regA,
  input  logic [3:0]      regB,
  input  logic [PC_W-1:0] regX,
  input  logic [PC_W-1:0] regY,
  input  logic [3:0]      flagsIn,
  input  logic [3:0]      memRdata,
  input  logic [PC_W-1:0] stkRdata,
  output logic [PC_W-1:0] pc,
  output logic            busy,
  output logic [SP_W-1:0] sp1,
  output logic [SP_W-1:0] sp2,
  output logic [PC_W-1:0] memAddr,
  output logic            memWe,
  output logic [3:0]      memWdata,
  output logic [PC_W-1:0] stkAddr,
  output logic            stkWe,
  output logic [PC_W-1:0] stkWdata,
  output logic [3:0]      flagsOut,
  output logic            flagsWe,
  output logic [PC_W-1:0] xOut,
  output logic            xWe
);
  strobeT stb;

  brseq_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opcode(opcode),
    .carryF(flagsIn[1]), .zeroF(flagsIn[0]), .busy(busy), .stb(stb)
  );

  brseq_dpath #(
    .PC_W(PC_W), .SP_W(SP_W), .RESET_PC(RESET_PC),
    .SP1_INIT(SP1_INIT), .SP2_INIT(SP2_INIT), .VEC_BASE(VEC_BASE)
  ) dpath_i (
    .clk(clk), .rstN(rstN), .stb(stb), .regA(regA), .regB(regB),
    .regX(regX), .regY(regY), .flagsIn(flagsIn), .memRdata(memRdata),
    .stkRdata(stkRdata), .pc(pc), .sp1(sp1), .sp2(sp2),
    .memAddr(memAddr), .memWe(memWe), .memWdata(memWdata),
    .stkAddr(stkAddr), .stkWe(stkWe), .stkWdata(stkWdata),
    .flagsOut(flagsOut), .flagsWe(flagsWe), .xOut(xOut), .xWe(xWe)
  );
endmodule

// File: rtl/brseq_chk.sv
module brseq_chk #(
  parameter int PC_W = 16,
  parameter int SP_W = 8
) (
  input logic            clk,
  input logic            rstN,
  input logic            busy,
  input logic [PC_W-1:0] pc,
  input logic [SP_W-1:0] sp1,
  input logic [SP_W-1:0] sp2,
  input logic            memWe,
  input logic            stkWe,
  input logic            flagsWe,
  input logic            xWe
);
  localparam logic [SP_W-1:0] ONE = SP_W'(1);

  AST_PC_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rstN) busy |=> $stable(pc)); // R13
  AST_BUSY_LIMIT: assert property (@(posedge clk) disable iff (!rstN) (busy && $past(busy)) |=> !busy); // R13
  AST_SP1_STEP: assert property (@(posedge clk) disable iff (!rstN) (sp1 != $past(sp1)) |-> (sp1 == $past(sp1) + ONE || sp1 == $past(sp1) - ONE)); // R7
  AST_SP2_STEP: assert property (@(posedge clk) disable iff (!rstN) (sp2 != $past(sp2)) |-> (sp2 == $past(sp2) + ONE || sp2 == $past(sp2) - ONE)); // R8
  AST_PUSH_DEC: assert property (@(posedge clk) disable iff (!rstN) stkWe |=> (sp1 == $past(sp1) - ONE)); // R7
  AST_FLAG_POP_READ: assert property (@(posedge clk) disable iff (!rstN) flagsWe |-> (!memWe && !stkWe)); // R11
  AST_X_UPDATE_QUIET: assert property (@(posedge clk) disable iff (!rstN) xWe |-> (!memWe && !stkWe)); // R12
endmodule

bind branch_sequencer brseq_chk #(.PC_W(PC_W), .SP_W(SP_W)) chk_i (
  .clk(clk), .rstN(rstN), .busy(busy), .pc(pc), .sp1(sp1), .sp2(sp2),
  .memWe(memWe), .stkWe(stkWe), .flagsWe(flagsWe), .xWe(xWe)
);

// File: tb/branch_sequencer_tb_top.sv
module branch_sequencer_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [12:0] opcode = '0;
  logic [3:0]  regA = 4'd3, regB = 4'd1;
  logic [15:0] regY = 16'h0300;
  logic [3:0]  fReg;
  logic [15:0] xReg;
  logic [3:0]  memRdata, memWdata, flagsOut;
  logic [15:0] stkRdata, pc, memAddr, stkAddr, stkWdata, xOut;
  logic        busy, memWe, stkWe, flagsWe, xWe;
  logic [7:0]  sp1, sp2;
  logic        fLoad = 1'b0;
  logic [3:0]  fLoadVal = '0;

  logic [3:0]  nmem [1024];
  logic [15:0] smem [256];

  always #4 clk = ~clk;

  branch_sequencer dut_i (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opcode(opcode),
    .regA(regA), .regB(regB), .regX(xReg), .regY(regY), .flagsIn(fReg),
    .memRdata(memRdata), .stkRdata(stkRdata), .pc(pc), .busy(busy),
    .sp1(sp1), .sp2(sp2), .memAddr(memAddr), .memWe(memWe),
    .memWdata(memWdata), .stkAddr(stkAddr), .stkWe(stkWe),
    .stkWdata(stkWdata), .flagsOut(flagsOut), .flagsWe(flagsWe),
    .xOut(xOut), .xWe(xWe)
  );

  assign memRdata = nmem[memAddr[9:0]];
  assign stkRdata = smem[stkAddr[9:2]];

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 1024; i++) nmem[i] <= 4'h0;
      for (int i = 0; i < 256; i++) smem[i] <= 16'h0;
      nmem[5] <= 4'hA;
      nmem[6] <= 4'h2;
      fReg <= 4'b0010;
      xReg <= 16'h0080;
    end else begin
      if (memWe) nmem[memAddr[9:0]] <= memWdata;
      if (stkWe) smem[stkAddr[9:2]] <= stkWdata;
      if (flagsWe) fReg <= flagsOut;
      else if (fLoad) fReg <= fLoadVal;
      if (xWe) xReg <= xOut;
    end
  end

  typedef struct {
    logic [15:0] pc;
    logic [7:0]  sp1;
    logic [7:0]  sp2;
    logic [3:0]  f;
    logic [15:0] x;
    int          cyc;
    string       tag;
  } expT;

  expT sbQ[$];
  int  nRun = 0, nFail = 0;
  bit  inInstr = 0, doneNext = 0, finished = 0;
  int  cyc = 0, lastCyc = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic expT mk(input logic [15:0] p, input logic [7:0] s1,
                             input logic [7:0] s2, input logic [3:0] f,
                             input logic [15:0] x, input int c, input string t);
    expT e;
    e.pc = p; e.sp1 = s1; e.sp2 = s2; e.f = f; e.x = x; e.cyc = c; e.tag = t;
    return e;
  endfunction

  // monitor: counts busy cycles, compares after the final edge
  always begin
    @(negedge clk);
    #2;
    if (doneNext) begin
      expT e;
      e = sbQ.pop_front();
      chk(pc == e.pc, e.tag, "pc", pc, e.pc);
      chk(sp1 == e.sp1, e.tag, "sp1", sp1, e.sp1);
      chk(sp2 == e.sp2, e.tag, "sp2", sp2, e.sp2);
      chk(fReg == e.f, e.tag, "flags", fReg, e.f);
      chk(xReg == e.x, e.tag, "X", xReg, e.x);
      chk(lastCyc == e.cyc, e.tag, "cycles", lastCyc, e.cyc);
      doneNext = 0;
    end else if (inInstr) begin
      cyc++;
      if (!busy) begin
        lastCyc = cyc;
        cyc = 0;
        inInstr = 0;
        doneNext = 1;
      end
    end
  end

  // driver: issues one opcode and pushes the expected outcome
  task automatic run(input logic [12:0] op, input expT e, input bit junk);
    @(negedge clk);
    #1;
    opcode = op;
    opValid = 1'b1;
    sbQ.push_back(e);
    inInstr = 1;
    @(negedge clk);
    #1;
    if (junk) begin
      opcode = 13'h0005;
      while (busy) begin @(negedge clk); #1; end
    end
    opValid = 1'b0;
    while (inInstr || doneNext || sbQ.size() != 0) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #2;
    chk(pc == 16'h0000, "R1", "pc", pc, 0);
    chk(sp1 == 8'd64, "R1", "sp1", sp1, 64);
    chk(sp2 == 8'd200, "R1", "sp2", sp2, 200);
    chk(busy == 1'b0, "R1", "busy", busy, 0);

    run(13'h0800, mk(16'h0001, 64, 200, 4'h2, 16'h80, 1, "R2"), 0);
    run(13'h0005, mk(16'h0007, 64, 200, 4'h2, 16'h80, 1, "R3"), 0);
    run(13'h00FD, mk(16'h0005, 64, 200, 4'h2, 16'h80, 1, "R3"), 0);
    run(13'h040A, mk(16'h0010, 64, 200, 4'h2, 16'h80, 1, "R4"), 0);
    run(13'h050A, mk(16'h0011, 64, 200, 4'h2, 16'h80, 1, "R4"), 0);
    run(13'h0604, mk(16'h0012, 64, 200, 4'h2, 16'h80, 1, "R4"), 0);
    run(13'h0704, mk(16'h0017, 64, 200, 4'h2, 16'h80, 1, "R4"), 0);
    run(13'h1FF1, mk(16'h001B, 64, 200, 4'h2, 16'h80, 1, "R5"), 0);
    run(13'h1FF0, mk(16'h002F, 64, 200, 4'h2, 16'h80, 1, "R5"), 0);
    run(13'h1FF3, mk(16'h0300, 64, 200, 4'h2, 16'h80, 1, "R5"), 0);
    run(13'h1F45, mk(16'h032B, 64, 200, 4'h2, 16'h80, 2, "R6"), 0);
    run(13'h0340, mk(16'h0040, 63, 200, 4'h2, 16'h80, 1, "R7"), 0);
    chk(smem[63] == 16'h032C, "R7", "stack[63]", smem[63], 16'h032C);
    run(13'h02FE, mk(16'h003F, 62, 200, 4'h2, 16'h80, 1, "R7"), 0);
    chk(smem[62] == 16'h0041, "R7", "stack[62]", smem[62], 16'h0041);
    run(13'h1FF8, mk(16'h0041, 63, 200, 4'h2, 16'h80, 1, "R9"), 0);
    run(13'h1FFB, mk(16'h032D, 64, 200, 4'h2, 16'h80, 2, "R10"), 0);
    run(13'h1F05, mk(16'h0358, 63, 200, 4'h2, 16'h80, 2, "R7"), 0);
    chk(smem[63] == 16'h032E, "R7", "stack[63]", smem[63], 16'h032E);
    // R13: junk opcode held valid during the busy cycles must be ignored
    run(13'h1F95, mk(16'h0115, 62, 199, 4'h2, 16'h80, 3, "R8"), 1);
    chk(nmem[199] == 4'h2, "R8", "flag stack", nmem[199], 4'h2);
    chk(smem[62] == 16'h0359, "R8", "stack[62]", smem[62], 16'h0359);

    @(negedge clk); #1; fLoad = 1'b1; fLoadVal = 4'b0101;
    @(negedge clk); #1; fLoad = 1'b0;
    run(13'h1FF9, mk(16'h0359, 63, 200, 4'h2, 16'h80, 2, "R11"), 0);
    run(13'h119C, mk(16'h032E, 64, 200, 4'h2, 16'h82, 3, "R12"), 0);
    chk(nmem[128] == 4'hC, "R12", "mem[X]", nmem[128], 4'hC);
    chk(nmem[129] == 4'h9, "R12", "mem[X+1]", nmem[129], 4'h9);
    run(13'h0310, mk(16'h0010, 63, 200, 4'h2, 16'h82, 1, "R7"), 0);
    run(13'h1FFA, mk(16'h032F, 64, 200, 4'h2, 16'h82, 1, "R9"), 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!finished) begin
      chk(1'b0, "WATCHDOG", "timeout", 0, 1);
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule